// File: doc/BRIEF.md
# Two-Channel Indirect Configuration Window

This block holds the setup state of a two-channel disk host controller and exposes it through only two host-visible locations. One is a byte-wide pointer that names a channel and one of seven register slots. The other is a word-wide data window that reads or writes whichever slot the pointer currently names. The pointer also carries four bus option bits of its own. One of them makes the slot number advance by itself after every data-window access, so software can stream the whole bank in one pass.

Every stored field is driven out as a separate signal for the rest of the controller:

- the command-block and control-block base addresses;
- the general configuration flags;
- the 10-bit read-ahead count and its enables;
- a one-cycle FIFO flush strobe;
- the data-port and command-port cycle timings, decoded from their 2/3/3-bit codes into plain clock counts.

Host address decoding sits outside this block, and so does any logic that uses these fields. The reset input is asserted asynchronously and released through a two-stage synchronizer. All registers therefore leave reset two clock edges after `rst_n` rises.

Top module: `chan_cfg_window`

## Requirements
- R1: After reset the registers hold these values:
  - pointer: 0x50;
  - channel 0: slot 0 = 0x01F0 and slot 4 = 0x03F6;
  - channel 1: slot 0 = 0x0170 and slot 4 = 0x0376;
  - both channels: slot 1 = 0x01, slot 5 = 0xF5, slot 6 = 0xDE, and the read-ahead state is all zero.
- R2: A write with `acc_ptr`=1 loads the pointer. Its bit fields are:
  - bits 2..0: slot number;
  - bit 3: channel;
  - bit 4: medium device-select timing;
  - bit 5: burst disable;
  - bit 6: one posted-write wait state;
  - bit 7: auto-advance.

  A pointer read returns these bits, except that bit 5 always reads 0.
- R3: A data access (`acc_ptr`=0) goes to the slot named by the pointer, in the channel named by the pointer.
  - Slots 0 and 4 hold all 16 bits.
  - Slots 1, 5 and 6 keep bits 7..0 only and read 0 in bits 15..8.
- R4: Slots 2 and 3 are write-only and read as 0. Bit 2 of slot 1 is write-only: it reads as 0 but still drives `pwr_save`.
- R5: Slot 1 drives these outputs:
  - bit 7: `dma_en`
  - bit 6: `drv_reset`
  - bit 5: `iordy_en`
  - bit 4: `port8`
  - bit 3: `irq_low`
  - bit 2: `pwr_save`
  - bit 1: `bm_mode`
  - bit 0: `io_en`
- R6: The read-ahead outputs come from slots 2 and 3:
  - `ra_count` is {slot 3 bits 1..0, slot 2 bits 7..0}.
  - `ra_en` is slot 3 bit 7.
  - `mode4_en` is slot 3 bit 4.
- R7: Writing slot 3 with bit 6 set raises that channel's `fifo_clear` for exactly one cycle, in the cycle after the write edge. The bit is not stored and does not alter the other fields of slot 3.
- R8: Slots 5 and 6 each decode into three clock counts. For a code value c:
  - setup = bits 7..6 plus 1;
  - hold (bits 5..3) = c+1 for c below 6, and 8 or 12 for c = 6 or 7;
  - active (bits 2..0) = c+2 for c below 5, and 8, 12 or 16 for c = 5, 6 or 7.
- R9: When auto-advance is set, every data-window read or write moves the slot number by one after the access. Slot 6 and slot 7 move to slot 0. The channel bit never changes.
- R10: The slot number does not move when auto-advance is clear, and it never moves on a pointer access.
- R11: Slot 7 is empty. Writes to it change nothing, and reads from it return 0.
- R12: A data write changes only the channel named by the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ptr | input | 1 | 1 = pointer location, 0 = data window |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for the access in the current cycle |
| ptr_index | output | 3 | Current slot number |
| ptr_chan | output | 1 | Current channel |
| ptr_autoinc | output | 1 | Auto-advance enabled |
| ptr_wait1 | output | 1 | One posted-write wait state |
| ptr_burst_off | output | 1 | Master burst disabled |
| ptr_devsel_med | output | 1 | Medium device-select timing |
| cmd_base | output | 2x16 | Command-block base per channel |
| ctl_base | output | 2x16 | Control-block base per channel |
| dma_en | output | 2 | DMA enable per channel |
| drv_reset | output | 2 | Drive reset request per channel |
| iordy_en | output | 2 | IORDY enable per channel |
| port8 | output | 2 | 8-bit data port per channel |
| irq_low | output | 2 | Interrupt active-low per channel |
| pwr_save | output | 2 | Power saving per channel |
| bm_mode | output | 2 | Bus-master mode per channel |
| io_en | output | 2 | I/O port enable per channel |
| ra_count | output | 2x10 | Read-ahead count per channel |
| ra_en | output | 2 | Read-ahead enable per channel |
| mode4_en | output | 2 | Mode-4 timing enable per channel |
| fifo_clear | output | 2 | One-cycle FIFO flush strobe per channel |
| dat_setup | output | 2x5 | Data-port setup clocks |
| dat_hold | output | 2x5 | Data-port hold clocks |
| dat_active | output | 2x5 | Data-port active clocks |
| cmd_setup | output | 2x5 | Command-port setup clocks |
| cmd_hold | output | 2x5 | Command-port hold clocks |
| cmd_active | output | 2x5 | Command-port active clocks |

## Verification
A corrupted stored field shows up on its exported output one clock after the write edge. It also shows up in `acc_rdata` on the very next read of that slot. A wrong slot number or channel bit in the pointer does not appear on any field output. It surfaces only when a later data access reads or lands in the wrong slot, so the bench reads back every slot after each advance and after each wrap. A stuck or mistimed flush strobe is visible at `fifo_clear` in the cycle right after the slot 3 write. The bench checks that cycle and the one after it.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  localparam int CHAN_N   = 2;
  localparam int DATA_W   = 16;
  localparam int IDX_W    = 3;
  localparam int IDX_LAST = 6;
  localparam int CLK_W    = 5;
  localparam int RA_W     = 10;

  localparam logic [DATA_W-1:0] CMD_BASE_PRI = 16'h01F0;
  localparam logic [DATA_W-1:0] CTL_BASE_PRI = 16'h03F6;
  localparam logic [DATA_W-1:0] SEC_XOR      = 16'h0080;
  localparam logic [7:0]        GEN_RST      = 8'h01;
  localparam logic [7:0]        DTIM_RST     = 8'hF5;
  localparam logic [7:0]        CTIM_RST     = 8'hDE;
  localparam logic [7:0]        PTR_RST      = 8'h50;

  typedef enum logic [IDX_W-1:0] {
    IX_CMD_BASE = 3'd0,
    IX_GEN      = 3'd1,
    IX_RA_LO    = 3'd2,
    IX_RA_CFG   = 3'd3,
    IX_CTL_BASE = 3'd4,
    IX_DTIM     = 3'd5,
    IX_CTIM     = 3'd6,
    IX_NONE     = 3'd7
  } idx_e;

  typedef struct packed {
    logic [CLK_W-1:0] setup;
    logic [CLK_W-1:0] hold;
    logic [CLK_W-1:0] active;
  } timing_t;

  function automatic logic [DATA_W-1:0] cmd_base_rst(input int ch);
    return (ch == 0) ? CMD_BASE_PRI : (CMD_BASE_PRI ^ SEC_XOR);
  endfunction

  function automatic logic [DATA_W-1:0] ctl_base_rst(input int ch);
    return (ch == 0) ? CTL_BASE_PRI : (CTL_BASE_PRI ^ SEC_XOR);
  endfunction

endpackage

// File: rtl/cfgw_timing_dec.sv
module cfgw_timing_dec
  import cfgw_pkg::*;
(
  input  logic [7:0] code,
  output timing_t    clocks
);

  logic [1:0] su_code;
  logic [2:0] ho_code;
  logic [2:0] ac_code;

  assign su_code = code[7:6];
  assign ho_code = code[5:3];
  assign ac_code = code[2:0];

  always_comb begin
    clocks.setup = {3'b000, su_code} + 5'd1;
    case (ho_code)
      3'd6:    clocks.hold = 5'd8;
      3'd7:    clocks.hold = 5'd12;
      default: clocks.hold = {2'b00, ho_code} + 5'd1;
    endcase
    case (ac_code)
      3'd5:    clocks.active = 5'd8;
      3'd6:    clocks.active = 5'd12;
      3'd7:    clocks.active = 5'd16;
      default: clocks.active = {2'b00, ac_code} + 5'd2;
    endcase
  end

endmodule

// File: rtl/cfgw_pointer.sv
module cfgw_pointer
  import cfgw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic             acc_ptr,
  input  logic [7:0]       wdata,
  output logic [IDX_W-1:0] idx,
  output logic             chan,
  output logic             autoinc,
  output logic             wait1,
  output logic             burst_off,
  output logic             devsel_med,
  output logic [7:0]       rdata
);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             chan_q, chan_d;
  logic             auto_q, auto_d;
  logic             wait_q, wait_d;
  logic             boff_q, boff_d;
  logic             dsel_q, dsel_d;
  logic             ptr_wr;
  logic             data_acc;
  logic             step;
  logic             load_en;

  assign ptr_wr   = acc_en & acc_wr & acc_ptr;
  assign data_acc = acc_en & ~acc_ptr;
  assign step     = data_acc & auto_q;
  assign load_en  = ptr_wr | step;

  always_comb begin
    idx_d  = idx_q;
    chan_d = chan_q;
    auto_d = auto_q;
    wait_d = wait_q;
    boff_d = boff_q;
    dsel_d = dsel_q;
    if (ptr_wr) begin
      idx_d  = wdata[2:0];
      chan_d = wdata[3];
      dsel_d = wdata[4];
      boff_d = wdata[5];
      wait_d = wdata[6];
      auto_d = wdata[7];
    end else if (step) begin
      if (idx_q >= IDX_W'(IDX_LAST)) idx_d = '0;
      else                           idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= PTR_RST[2:0];
      chan_q <= PTR_RST[3];
      dsel_q <= PTR_RST[4];
      boff_q <= PTR_RST[5];
      wait_q <= PTR_RST[6];
      auto_q <= PTR_RST[7];
    end else if (load_en) begin
      idx_q  <= idx_d;
      chan_q <= chan_d;
      dsel_q <= dsel_d;
      boff_q <= boff_d;
      wait_q <= wait_d;
      auto_q <= auto_d;
    end
  end

  assign idx        = idx_q;
  assign chan       = chan_q;
  assign autoinc    = auto_q;
  assign wait1      = wait_q;
  assign burst_off  = boff_q;
  assign devsel_med = dsel_q;
  assign rdata      = {auto_q, wait_q, 1'b0, dsel_q, chan_q, idx_q};

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (idx_q == $past(wdata[2:0])) && (chan_q == $past(wdata[3])));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && auto_q && idx_q >= 3'd6) |=> (idx_q == 3'd0));

  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && auto_q && idx_q < 3'd6) |=> (idx_q == $past(idx_q) + 3'd1) && $stable(chan_q));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !auto_q) |=> $stable(idx_q));

endmodule

// File: rtl/cfgw_bank.sv
module cfgw_bank
  import cfgw_pkg::*;
#(
  parameter logic [DATA_W-1:0] CMD_RST = CMD_BASE_PRI,
  parameter logic [DATA_W-1:0] CTL_RST = CTL_BASE_PRI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] cmd_base,
  output logic [DATA_W-1:0] ctl_base,
  output logic [7:0]        gen_flags,
  output logic [RA_W-1:0]   ra_count,
  output logic              ra_en,
  output logic              mode4_en,
  output logic              fifo_clear,
  output timing_t           dat_tim,
  output timing_t           cmd_tim
);

  localparam int TIM_N = 2;

  logic [DATA_W-1:0]       cmd_q, cmd_d;
  logic [DATA_W-1:0]       ctl_q, ctl_d;
  logic [7:0]              gen_q, gen_d;
  logic [7:0]              ralo_q, ralo_d;
  logic [3:0]              racfg_q, racfg_d;
  logic [TIM_N-1:0][7:0]   tim_q, tim_d;
  logic                    flush_q, flush_d;
  timing_t                 tim_dec [TIM_N];

  always_comb begin
    cmd_d   = cmd_q;
    ctl_d   = ctl_q;
    gen_d   = gen_q;
    ralo_d  = ralo_q;
    racfg_d = racfg_q;
    tim_d   = tim_q;
    flush_d = 1'b0;
    if (wr_en) begin
      case (idx_e'(idx))
        IX_CMD_BASE: cmd_d    = wdata;
        IX_GEN:      gen_d    = wdata[7:0];
        IX_RA_LO:    ralo_d   = wdata[7:0];
        IX_RA_CFG: begin
          racfg_d = {wdata[7], wdata[4], wdata[1:0]};
          flush_d = wdata[6];
        end
        IX_CTL_BASE: ctl_d    = wdata;
        IX_DTIM:     tim_d[0] = wdata[7:0];
        IX_CTIM:     tim_d[1] = wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_RST;
      ctl_q   <= CTL_RST;
      gen_q   <= GEN_RST;
      ralo_q  <= '0;
      racfg_q <= '0;
      tim_q   <= {CTIM_RST, DTIM_RST};
      flush_q <= 1'b0;
    end else begin
      if (wr_en) begin
        cmd_q   <= cmd_d;
        ctl_q   <= ctl_d;
        gen_q   <= gen_d;
        ralo_q  <= ralo_d;
        racfg_q <= racfg_d;
        tim_q   <= tim_d;
      end
      flush_q <= flush_d;
    end
  end

  always_comb begin
    case (idx_e'(idx))
      IX_CMD_BASE: rdata = cmd_q;
      IX_GEN:      rdata = {8'h00, gen_q & 8'hFB};
      IX_CTL_BASE: rdata = ctl_q;
      IX_DTIM:     rdata = {8'h00, tim_q[0]};
      IX_CTIM:     rdata = {8'h00, tim_q[1]};
      default:     rdata = '0;
    endcase
  end

  for (genvar t = 0; t < TIM_N; t++) begin : g_tim
    cfgw_timing_dec u_dec (
      .code   (tim_q[t]),
      .clocks (tim_dec[t])
    );
  end

  assign cmd_base   = cmd_q;
  assign ctl_base   = ctl_q;
  assign gen_flags  = gen_q;
  assign ra_count   = {racfg_q[1:0], ralo_q};
  assign ra_en      = racfg_q[3];
  assign mode4_en   = racfg_q[2];
  assign fifo_clear = flush_q;
  assign dat_tim    = tim_dec[0];
  assign cmd_tim    = tim_dec[1];

  assert_flush_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> $past(wr_en && idx == 3'd3 && wdata[6]));

  assert_empty_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 3'd7) |=> $stable(cmd_q) && $stable(ctl_q) && $stable(gen_q)
      && $stable(ralo_q) && $stable(racfg_q) && $stable(tim_q));

  assert_ra_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(racfg_q) && $stable(ralo_q));

endmodule

// File: rtl/chan_cfg_window.sv
module chan_cfg_window
  import cfgw_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_en,
  input  logic                          acc_wr,
  input  logic                          acc_ptr,
  input  logic [DATA_W-1:0]             acc_wdata,
  output logic [DATA_W-1:0]             acc_rdata,
  output logic [IDX_W-1:0]              ptr_index,
  output logic                          ptr_chan,
  output logic                          ptr_autoinc,
  output logic                          ptr_wait1,
  output logic                          ptr_burst_off,
  output logic                          ptr_devsel_med,
  output logic [CHAN_N-1:0][DATA_W-1:0] cmd_base,
  output logic [CHAN_N-1:0][DATA_W-1:0] ctl_base,
  output logic [CHAN_N-1:0]             dma_en,
  output logic [CHAN_N-1:0]             drv_reset,
  output logic [CHAN_N-1:0]             iordy_en,
  output logic [CHAN_N-1:0]             port8,
  output logic [CHAN_N-1:0]             irq_low,
  output logic [CHAN_N-1:0]             pwr_save,
  output logic [CHAN_N-1:0]             bm_mode,
  output logic [CHAN_N-1:0]             io_en,
  output logic [CHAN_N-1:0][RA_W-1:0]   ra_count,
  output logic [CHAN_N-1:0]             ra_en,
  output logic [CHAN_N-1:0]             mode4_en,
  output logic [CHAN_N-1:0]             fifo_clear,
  output logic [CHAN_N-1:0][CLK_W-1:0]  dat_setup,
  output logic [CHAN_N-1:0][CLK_W-1:0]  dat_hold,
  output logic [CHAN_N-1:0][CLK_W-1:0]  dat_active,
  output logic [CHAN_N-1:0][CLK_W-1:0]  cmd_setup,
  output logic [CHAN_N-1:0][CLK_W-1:0]  cmd_hold,
  output logic [CHAN_N-1:0][CLK_W-1:0]  cmd_active
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0]             rst_pipe;
  logic                          rst_core_n;
  logic [7:0]                    ptr_rd;
  logic [CHAN_N-1:0][DATA_W-1:0] bank_rd;
  logic [CHAN_N-1:0][7:0]        gen_w;
  timing_t                       dtim_w [CHAN_N];
  timing_t                       ctim_w [CHAN_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_N-1];

  cfgw_pointer u_ptr (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .acc_ptr    (acc_ptr),
    .wdata      (acc_wdata[7:0]),
    .idx        (ptr_index),
    .chan       (ptr_chan),
    .autoinc    (ptr_autoinc),
    .wait1      (ptr_wait1),
    .burst_off  (ptr_burst_off),
    .devsel_med (ptr_devsel_med),
    .rdata      (ptr_rd)
  );

  for (genvar g = 0; g < CHAN_N; g++) begin : g_bank
    logic bank_wr;
    assign bank_wr = acc_en & acc_wr & ~acc_ptr & (ptr_chan == 1'(g));

    cfgw_bank #(
      .CMD_RST (cmd_base_rst(g)),
      .CTL_RST (ctl_base_rst(g))
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .wr_en      (bank_wr),
      .idx        (ptr_index),
      .wdata      (acc_wdata),
      .rdata      (bank_rd[g]),
      .cmd_base   (cmd_base[g]),
      .ctl_base   (ctl_base[g]),
      .gen_flags  (gen_w[g]),
      .ra_count   (ra_count[g]),
      .ra_en      (ra_en[g]),
      .mode4_en   (mode4_en[g]),
      .fifo_clear (fifo_clear[g]),
      .dat_tim    (dtim_w[g]),
      .cmd_tim    (ctim_w[g])
    );

    assign dma_en[g]     = gen_w[g][7];
    assign drv_reset[g]  = gen_w[g][6];
    assign iordy_en[g]   = gen_w[g][5];
    assign port8[g]      = gen_w[g][4];
    assign irq_low[g]    = gen_w[g][3];
    assign pwr_save[g]   = gen_w[g][2];
    assign bm_mode[g]    = gen_w[g][1];
    assign io_en[g]      = gen_w[g][0];
    assign dat_setup[g]  = dtim_w[g].setup;
    assign dat_hold[g]   = dtim_w[g].hold;
    assign dat_active[g] = dtim_w[g].active;
    assign cmd_setup[g]  = ctim_w[g].setup;
    assign cmd_hold[g]   = ctim_w[g].hold;
    assign cmd_active[g] = ctim_w[g].active;
  end

  assign acc_rdata = acc_ptr ? {8'h00, ptr_rd} : bank_rd[ptr_chan];

  assert_wo_zero_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_en && !acc_wr && !acc_ptr && (ptr_index == 3'd2 || ptr_index == 3'd3))
      |-> (acc_rdata == 16'h0000));

  assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_en && !acc_wr && !acc_ptr && ptr_index == 3'd7) |-> (acc_rdata == 16'h0000));

  assert_ptr_bit5_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_en && acc_ptr) |-> (acc_rdata[15:8] == 8'h00) && !acc_rdata[5]);

  assert_isolate_R12: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_en && acc_wr && !acc_ptr) |=> $stable(cmd_base[~$past(ptr_chan)]));

  assert_flush_onehot_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(fifo_clear));

endmodule

// File: tb/chan_cfg_window_tb.sv
module chan_cfg_window_tb;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             acc_en, acc_wr, acc_ptr;
  logic [15:0]      acc_wdata;
  logic [15:0]      acc_rdata;
  logic [2:0]       ptr_index;
  logic             ptr_chan, ptr_autoinc, ptr_wait1, ptr_burst_off, ptr_devsel_med;
  logic [1:0][15:0] cmd_base, ctl_base;
  logic [1:0]       dma_en, drv_reset, iordy_en, port8, irq_low, pwr_save, bm_mode, io_en;
  logic [1:0][9:0]  ra_count;
  logic [1:0]       ra_en, mode4_en, fifo_clear;
  logic [1:0][4:0]  dat_setup, dat_hold, dat_active, cmd_setup, cmd_hold, cmd_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chan_cfg_window u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_ptr(acc_ptr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .ptr_index(ptr_index),
    .ptr_chan(ptr_chan), .ptr_autoinc(ptr_autoinc), .ptr_wait1(ptr_wait1),
    .ptr_burst_off(ptr_burst_off), .ptr_devsel_med(ptr_devsel_med),
    .cmd_base(cmd_base), .ctl_base(ctl_base), .dma_en(dma_en), .drv_reset(drv_reset),
    .iordy_en(iordy_en), .port8(port8), .irq_low(irq_low), .pwr_save(pwr_save),
    .bm_mode(bm_mode), .io_en(io_en), .ra_count(ra_count), .ra_en(ra_en),
    .mode4_en(mode4_en), .fifo_clear(fifo_clear), .dat_setup(dat_setup),
    .dat_hold(dat_hold), .dat_active(dat_active), .cmd_setup(cmd_setup),
    .cmd_hold(cmd_hold), .cmd_active(cmd_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc_write(input logic p, input logic [15:0] v);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_ptr = p; acc_wdata = v;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic acc_read(input logic p, output logic [15:0] v);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_ptr = p;
    #1 v = acc_rdata;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  function automatic int exp_hold(input int c);
    return (c < 6) ? c + 1 : (c - 4) * 4;
  endfunction

  function automatic int exp_active(input int c);
    return (c < 5) ? c + 2 : (c - 3) * 4;
  endfunction

  function automatic int exp_default(input int ch, input int k);
    case (k)
      0: return 'h1F0 - ch * 'h80;
      1: return 'h01;
      4: return 'h3F6 - ch * 'h80;
      5: return 'hF5;
      6: return 'hDE;
      default: return 0;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] rv;
    acc_en = 0; acc_wr = 0; acc_ptr = 0; acc_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 / R2: reset pointer value and its fields
    acc_read(1'b1, rv);
    chk("R1 ptr reset", rv, 'h50);
    chk("R2 devsel reset", ptr_devsel_med, 1);
    chk("R2 wait reset", ptr_wait1, 1);

    // R1 / R9: auto-advance through every slot of each channel, wrapping at 6
    for (int ch = 0; ch < 2; ch++) begin
      chk("R1 cmd_base out", cmd_base[ch], exp_default(ch, 0));
      chk("R1 ctl_base out", ctl_base[ch], exp_default(ch, 4));
      chk("R1 io_en out", io_en[ch], 1);
      chk("R1 dat timing", {dat_setup[ch], dat_hold[ch], dat_active[ch]}, {5'd4, 5'd8, 5'd8});
      chk("R1 cmd timing", {cmd_setup[ch], cmd_hold[ch], cmd_active[ch]}, {5'd4, 5'd4, 5'd12});
      chk("R1 ra_count", ra_count[ch], 0);
      acc_write(1'b1, 16'(8'h80 | (ch << 3)));
      for (int k = 0; k < 9; k++) begin
        acc_read(1'b0, rv);
        chk("R9 R1 autoinc read", rv, exp_default(ch, k % 7));
      end
      chk("R9 index after wraps", ptr_index, 2);
      chk("R9 chan kept", ptr_chan, ch);
    end

    // R2: every pointer value, bit 5 reads back as zero
    for (int v = 0; v < 256; v++) begin
      acc_write(1'b1, 16'(v));
      acc_read(1'b1, rv);
      chk("R2 ptr readback", rv, v & 'hDF);
      chk("R2 burst_off out", ptr_burst_off, (v >> 5) & 1);
    end

    // R8 / R3: timing sweep on both channels and both timing slots
    for (int ch = 0; ch < 2; ch++) begin
      for (int s = 5; s < 7; s++) begin
        acc_write(1'b1, 16'(s | (ch << 3)));
        for (int v = 0; v < 256; v++) begin
          acc_write(1'b0, 16'(v | 'hA500));
          if (s == 5)
            chk("R8 dat decode", {dat_setup[ch], dat_hold[ch], dat_active[ch]},
                {5'((v >> 6) + 1), 5'(exp_hold((v >> 3) & 7)), 5'(exp_active(v & 7))});
          else
            chk("R8 cmd decode", {cmd_setup[ch], cmd_hold[ch], cmd_active[ch]},
                {5'((v >> 6) + 1), 5'(exp_hold((v >> 3) & 7)), 5'(exp_active(v & 7))});
          acc_read(1'b0, rv);
          chk("R3 byte slot readback", rv, v);
        end
      end
    end

    // R5 / R4: general config sweep on channel 1, channel 0 untouched (R12)
    acc_write(1'b1, 16'h0009);
    for (int v = 0; v < 256; v++) begin
      acc_write(1'b0, 16'(v));
      chk("R5 gen fields", {dma_en[1], drv_reset[1], iordy_en[1], port8[1], irq_low[1],
                           pwr_save[1], bm_mode[1], io_en[1]}, v);
      acc_read(1'b0, rv);
      chk("R4 gen readback bit2 hidden", rv, v & 'hFB);
      chk("R10 index held", ptr_index, 1);
    end
    chk("R12 ch0 gen untouched", {dma_en[0], pwr_save[0], io_en[0]}, 3'b001);

    // R3 / R12: word slots
    acc_write(1'b1, 16'h0008);
    acc_write(1'b0, 16'hABCD);
    acc_read(1'b0, rv);
    chk("R3 word slot readback", rv, 'hABCD);
    chk("R12 ch0 cmd_base kept", cmd_base[0], 'h1F0);
    chk("R3 ch1 cmd_base out", cmd_base[1], 'hABCD);
    acc_write(1'b1, 16'h0004);
    acc_write(1'b0, 16'h1234);
    chk("R3 ctl_base out", ctl_base[0], 'h1234);
    chk("R12 ch1 ctl kept", ctl_base[1], 'h376);

    // R6 / R4: read-ahead slots, auto-advance writes from slot 2 to 3
    acc_write(1'b1, 16'h0082);
    acc_write(1'b0, 16'h005A);
    acc_write(1'b0, 16'h0093);
    chk("R6 ra_count", ra_count[0], 'h35A);
    chk("R6 ra_en", ra_en[0], 1);
    chk("R6 mode4", mode4_en[0], 1);
    chk("R9 index after two writes", ptr_index, 4);
    acc_write(1'b1, 16'h0002);
    acc_read(1'b0, rv);
    chk("R4 slot2 reads zero", rv, 0);
    acc_write(1'b1, 16'h0003);
    acc_read(1'b0, rv);
    chk("R4 slot3 reads zero", rv, 0);

    // R7: flush strobe timing and no storage
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_ptr = 0; acc_wdata = 16'h00C1;
    #1 chk("R7 no strobe before edge", fifo_clear, 0);
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
    chk("R7 strobe after write", fifo_clear, 'b01);
    chk("R7 ra_count updated", ra_count[0], 'h15A);
    @(negedge clk);
    chk("R7 strobe one cycle", fifo_clear, 0);
    acc_write(1'b0, 16'h0081);
    chk("R7 no strobe without bit6", fifo_clear, 0);

    // R11: empty slot
    acc_write(1'b1, 16'h0007);
    acc_write(1'b0, 16'hFFFF);
    acc_read(1'b0, rv);
    chk("R11 slot7 reads zero", rv, 0);
    chk("R11 cmd_base kept", cmd_base[0], 'h1F0);
    chk("R11 ctl_base kept", ctl_base[0], 'h1234);
    chk("R11 ra kept", {ra_en[0], ra_count[0]}, {1'b1, 10'h15A});
    acc_write(1'b1, 16'h0087);
    acc_read(1'b0, rv);
    chk("R9 slot7 wraps to 0", ptr_index, 0);

    // R10: pointer accesses never advance
    acc_write(1'b1, 16'h0085);
    acc_read(1'b1, rv);
    acc_read(1'b1, rv);
    chk("R10 ptr read no step", ptr_index, 5);

    finish_run();
  end

endmodule